// File: doc/BRIEF.md
# Processor Controller Datapath-Control Decoder

This block is the output half of a multi-cycle processor controller. Each cycle it receives the strobe of the current sequencer step and the instruction word's opcode and destination-register field. From these it produces every datapath control for that cycle:

- load enables for the address register, the memory-data register and one general register;
- the shifter function;
- the ALU function and carry-in;
- the source select of the internal bus.

The outputs are a Mealy function of the step strobe and the instruction. They are purely combinational, and clock gating is modelled as load enables.

The sequencer steps are three fetch steps, FETCH1, FETCH2 and FETCH3, followed by up to four execute steps, EXEC1 to EXEC4. The opcode is decoded internally into one line per mnemonic. Where an enable's value does not matter for correct execution, the enable is folded into a simpler expression. For example, the address register loads in FETCH1, EXEC1 and EXEC2 whatever the instruction.

Top module: `ctl_out_decode`

## Requirements
- R1: `ir_opcode` is {execute-cycle count in bits 7:5, mnemonic number in bits 4:0}. The legal codes are NOP 0x00, CLEAR 0x21, JUMP 0x22, STORE 0x43, ASL 0x44, ASR 0x45, LSR 0x46, MOVE 0x47, CALL 0x68, STOREI 0x69, LOAD 0x6A, INC 0x6B, DEC 0x6C, COMP 0x6D, ADD 0x6E, SUB 0x6F, AND 0x70, OR 0x71, COMPARE 0x72, CALLI 0x93 and LOADI 0x94. Any other code drives `shf_fn`, `alu_fn` and `alu_cin` to 0, and it sets no other output beyond what the step alone sets.
- R2: `ld_mar` is 1 exactly in FETCH1, EXEC1 and EXEC2, for every instruction. The bits of `stage_strb` are FETCH1 in bit 0, FETCH2 in bit 1, FETCH3 in bit 2, EXEC1 in bit 3, EXEC2 in bit 4, EXEC3 in bit 5 and EXEC4 in bit 6.
- R3: `ld_mdr` is 1 in three cases: in FETCH2, in EXEC2 of LOAD, and in EXEC3 of LOADI.
- R4: A register write happens in the following cases. When it does, `ld_reg` has only bit `ir_dst` set; otherwise `ld_reg` is 0.
  - in EXEC4, for every instruction;
  - in EXEC3, for LOAD, ADD, INC, DEC or COMP;
  - in EXEC2, for ASL, MOVE, CALL or CALLI;
  - in EXEC1, for CLEAR.
- R5: `shf_fn` depends on the instruction alone.
  - Bit 1 is set for ASR or LSR.
  - Bit 0 is set for ASL or LSR.
  - Every other instruction gives 00, which means no shift.
- R6: `alu_cin` is 1 only in EXEC3 of INC.
- R7: Each bit of `alu_fn` is set in EXEC2 of COMP or DEC. In EXEC3, the bits are set as follows:
  - bit 2 for COMP or AND;
  - bit 1 for SUB, COMPARE, DEC, INC, ADD or AND;
  - bit 0 for DEC, INC, ADD or OR.
- R8: `bus_sel` chooses the internal-bus source. It defaults to the shifter (000) and takes one of four other codes:
  - program counter (010) in EXEC2 of CALL or CALLI;
  - ALU (001) in EXEC1 of CLEAR, and in EXEC2 or EXEC3 of INC, DEC or COMP;
  - immediate mask (100) in EXEC1 of LOAD, JUMP or STORE, and in EXEC3 of CALL;
  - memory-data register (101) in EXEC3 of LOAD and in every EXEC4.
- R9: During CALL, `ld_mdr` stays 0 in EXEC1, EXEC2 and EXEC3.
- R10: With no step strobe set, `ld_mar`, `ld_mdr`, `ld_reg`, `alu_fn`, `alu_cin` and `bus_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stage_strb | input | 7 | One-hot sequencer step strobes, FETCH1 in bit 0 to EXEC4 in bit 6 |
| ir_opcode | input | 8 | Opcode field of the instruction register |
| ir_dst | input | 3 | Destination register index field of the instruction register |
| ld_mar | output | 1 | Address register load enable |
| ld_mdr | output | 1 | Memory-data register load enable |
| ld_reg | output | 8 | One-hot general-register load enables |
| shf_fn | output | 2 | Shifter function |
| alu_fn | output | 3 | ALU function |
| alu_cin | output | 1 | ALU carry-in |
| bus_sel | output | 3 | Internal-bus source select |

## Verification
The bench builds the block with the default parameters: an 8-bit opcode split 3/5, and a 3-bit destination field that yields eight register enables. These values bring the whole input space of interest within reach. The bench visits every step strobe and the all-idle case. For each one it applies all twenty-one mnemonics and four unassigned codes, rotating the destination index through all eight values. This exercises every product term of every enable and select, and every position of the one-hot register enable.

// File: rtl/cod_pkg.sv
package cod_pkg;

    localparam int CLS_W      = 3;
    localparam int IDX_W      = 5;
    localparam int OPC_W      = CLS_W + IDX_W;
    localparam int DST_W      = 3;
    localparam int NUM_REGS   = 1 << DST_W;
    localparam int NUM_STAGES = 7;
    localparam int NUM_MNEM   = 21;
    localparam int SEL_W      = 3;
    localparam int ALU_W      = 3;
    localparam int SHF_W      = 2;

    // Sequencer step, used as the bit index into the strobe vector.
    typedef enum logic [2:0] {
        ST_F1, ST_F2, ST_F3, ST_E1, ST_E2, ST_E3, ST_E4
    } stage_e;

    // Mnemonic number, used as the low opcode bits and the decode line index.
    typedef enum logic [IDX_W-1:0] {
        MN_NOP, MN_CLEAR, MN_JUMP, MN_STORE, MN_ASL, MN_ASR, MN_LSR,
        MN_MOVE, MN_CALL, MN_STOREI, MN_LOAD, MN_INC, MN_DEC, MN_COMP,
        MN_ADD, MN_SUB, MN_AND, MN_OR, MN_COMPARE, MN_CALLI, MN_LOADI
    } mnem_e;

    // Number of execute steps per mnemonic number (upper opcode bits).
    function automatic logic [CLS_W-1:0] exec_cycles(input int unsigned k);
        if (k == 0)       return CLS_W'(0);
        else if (k <= 2)  return CLS_W'(1);
        else if (k <= 7)  return CLS_W'(2);
        else if (k <= 18) return CLS_W'(3);
        else              return CLS_W'(4);
    endfunction

    function automatic logic [OPC_W-1:0] opcode_of(input int unsigned k);
        return {exec_cycles(k), IDX_W'(k)};
    endfunction

endpackage

// File: rtl/cod_instr_dec.sv
module cod_instr_dec #(
    parameter int OPC_W    = cod_pkg::OPC_W,
    parameter int NUM_MNEM = cod_pkg::NUM_MNEM
) (
    input  logic [OPC_W-1:0]    opcode,
    output logic [NUM_MNEM-1:0] lines
);
    // One compare per mnemonic; an unassigned code raises no line.
    for (genvar k = 0; k < NUM_MNEM; k++) begin : g_line
        assign lines[k] = (opcode == OPC_W'(cod_pkg::opcode_of(k)));
    end
endmodule

// File: rtl/cod_dst_dec.sv
module cod_dst_dec #(
    parameter int DST_W = cod_pkg::DST_W,
    localparam int NUM_REGS = 1 << DST_W
) (
    input  logic                en,
    input  logic [DST_W-1:0]    idx,
    output logic [NUM_REGS-1:0] onehot
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign onehot[i] = en && (idx == DST_W'(i));
    end
endmodule

// File: rtl/cod_ctl_eqn.sv
module cod_ctl_eqn
    import cod_pkg::*;
#(
    parameter int N_STG = cod_pkg::NUM_STAGES,
    parameter int N_MN  = cod_pkg::NUM_MNEM
) (
    input  logic [N_STG-1:0] stg,
    input  logic [N_MN-1:0]  ins,
    output logic             ld_mar,
    output logic             ld_mdr,
    output logic             reg_wr,
    output logic [SHF_W-1:0] shf_fn,
    output logic [ALU_W-1:0] alu_fn,
    output logic             alu_cin,
    output logic [SEL_W-1:0] bus_sel
);
    logic f1, f2, e1, e2, e3, e4;
    logic src_pc, src_alu, src_mask, src_mdr;
    logic e2_cd, e3_f2, e3_f1, e3_f0;
    logic unused_terms;

    assign f1 = stg[ST_F1];
    assign f2 = stg[ST_F2];
    assign e1 = stg[ST_E1];
    assign e2 = stg[ST_E2];
    assign e3 = stg[ST_E3];
    assign e4 = stg[ST_E4];

    // FETCH3, NOP and STOREI drive no control of their own here.
    assign unused_terms = stg[ST_F3] ^ ins[MN_NOP] ^ ins[MN_STOREI];

    // Load enables, folded over don't-care steps.
    always_comb begin
        ld_mar = f1 | e1 | e2;
        ld_mdr = f2 | (e2 & ins[MN_LOAD]) | (e3 & ins[MN_LOADI]);
        reg_wr = e4
               | (e3 & (ins[MN_LOAD] | ins[MN_ADD] | ins[MN_INC]
                      | ins[MN_DEC] | ins[MN_COMP]))
               | (e2 & (ins[MN_ASL] | ins[MN_MOVE] | ins[MN_CALL]
                      | ins[MN_CALLI]))
               | (e1 & ins[MN_CLEAR]);
    end

    // Shifter and ALU function.
    always_comb begin
        shf_fn[1] = ins[MN_ASR] | ins[MN_LSR];
        shf_fn[0] = ins[MN_ASL] | ins[MN_LSR];
        e2_cd     = e2 & (ins[MN_COMP] | ins[MN_DEC]);
        e3_f2     = ins[MN_COMP] | ins[MN_AND];
        e3_f1     = ins[MN_SUB] | ins[MN_COMPARE] | ins[MN_DEC]
                  | ins[MN_INC] | ins[MN_ADD] | ins[MN_AND];
        e3_f0     = ins[MN_DEC] | ins[MN_INC] | ins[MN_ADD] | ins[MN_OR];
        alu_fn[2] = (e3 & e3_f2) | e2_cd;
        alu_fn[1] = (e3 & e3_f1) | e2_cd;
        alu_fn[0] = (e3 & e3_f0) | e2_cd;
        alu_cin   = e3 & ins[MN_INC];
    end

    // Internal-bus source: merged source conditions onto select bits.
    always_comb begin
        src_pc   = e2 & (ins[MN_CALL] | ins[MN_CALLI]);
        src_alu  = (e1 & ins[MN_CLEAR])
                 | ((e2 | e3) & (ins[MN_INC] | ins[MN_DEC] | ins[MN_COMP]));
        src_mask = (e1 & (ins[MN_LOAD] | ins[MN_JUMP] | ins[MN_STORE]))
                 | (e3 & ins[MN_CALL]);
        src_mdr  = (e3 & ins[MN_LOAD]) | e4;
        bus_sel[0] = src_alu | src_mdr;
        bus_sel[1] = src_pc;
        bus_sel[2] = src_mask | src_mdr;
    end
endmodule

// File: rtl/ctl_out_decode.sv
module ctl_out_decode
    import cod_pkg::*;
(
    input  logic [NUM_STAGES-1:0] stage_strb,
    input  logic [OPC_W-1:0]      ir_opcode,
    input  logic [DST_W-1:0]      ir_dst,
    output logic                  ld_mar,
    output logic                  ld_mdr,
    output logic [NUM_REGS-1:0]   ld_reg,
    output logic [SHF_W-1:0]      shf_fn,
    output logic [ALU_W-1:0]      alu_fn,
    output logic                  alu_cin,
    output logic [SEL_W-1:0]      bus_sel
);
    logic [NUM_MNEM-1:0] ins_lines;
    logic                reg_wr;

    cod_instr_dec #(.OPC_W(OPC_W), .NUM_MNEM(NUM_MNEM)) u_idec (
        .opcode (ir_opcode),
        .lines  (ins_lines)
    );

    cod_ctl_eqn #(.N_STG(NUM_STAGES), .N_MN(NUM_MNEM)) u_eqn (
        .stg     (stage_strb),
        .ins     (ins_lines),
        .ld_mar  (ld_mar),
        .ld_mdr  (ld_mdr),
        .reg_wr  (reg_wr),
        .shf_fn  (shf_fn),
        .alu_fn  (alu_fn),
        .alu_cin (alu_cin),
        .bus_sel (bus_sel)
    );

    cod_dst_dec #(.DST_W(DST_W)) u_ddec (
        .en     (reg_wr),
        .idx    (ir_dst),
        .onehot (ld_reg)
    );
endmodule

// File: rtl/ctl_out_decode_chk.sv
module ctl_out_decode_chk
    import cod_pkg::*;
(
    input logic [NUM_STAGES-1:0] stage_strb,
    input logic [OPC_W-1:0]      ir_opcode,
    input logic [DST_W-1:0]      ir_dst,
    input logic                  ld_mar,
    input logic                  ld_mdr,
    input logic [NUM_REGS-1:0]   ld_reg,
    input logic [SHF_W-1:0]      shf_fn,
    input logic [ALU_W-1:0]      alu_fn,
    input logic                  alu_cin,
    input logic [SEL_W-1:0]      bus_sel
);
    always_comb begin
        if (!$isunknown({stage_strb, ir_opcode, ir_dst})) begin
            a_r4_one_dest: assert ($onehot0(ld_reg));
            a_r4_dest_idx: assert (ld_reg == '0 || ld_reg[ir_dst]);
            a_r6_cin_inc: assert (!alu_cin || (alu_fn == 3'b011 && stage_strb[ST_E3]));
            a_r8_bus_code: assert (bus_sel inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b101});
            a_r9_call_hold: assert (!(ir_opcode == opcode_of(MN_CALL) && ld_mdr
                && (stage_strb[ST_E1] || stage_strb[ST_E2] || stage_strb[ST_E3])));
            a_r10_idle: assert (stage_strb != '0 || (!ld_mar && !ld_mdr && ld_reg == '0
                && bus_sel == '0 && alu_fn == '0 && !alu_cin));
        end
    end
endmodule

bind ctl_out_decode ctl_out_decode_chk u_chk (
    .stage_strb (stage_strb),
    .ir_opcode  (ir_opcode),
    .ir_dst     (ir_dst),
    .ld_mar     (ld_mar),
    .ld_mdr     (ld_mdr),
    .ld_reg     (ld_reg),
    .shf_fn     (shf_fn),
    .alu_fn     (alu_fn),
    .alu_cin    (alu_cin),
    .bus_sel    (bus_sel)
);

// File: tb/ctl_out_decode_tb.sv
module ctl_out_decode_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] stage_strb = '0;
    logic [7:0] ir_opcode = '0;
    logic [2:0] ir_dst = '0;
    logic       ld_mar, ld_mdr, alu_cin;
    logic [7:0] ld_reg;
    logic [1:0] shf_fn;
    logic [2:0] alu_fn, bus_sel;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ctl_out_decode u_dut (
        .stage_strb (stage_strb), .ir_opcode (ir_opcode), .ir_dst (ir_dst),
        .ld_mar (ld_mar), .ld_mdr (ld_mdr), .ld_reg (ld_reg), .shf_fn (shf_fn),
        .alu_fn (alu_fn), .alu_cin (alu_cin), .bus_sel (bus_sel)
    );

    localparam logic [7:0] K_NOP=8'h00, K_CLEAR=8'h21, K_JUMP=8'h22, K_STORE=8'h43,
        K_ASL=8'h44, K_ASR=8'h45, K_LSR=8'h46, K_MOVE=8'h47, K_CALL=8'h68,
        K_STOREI=8'h69, K_LOAD=8'h6A, K_INC=8'h6B, K_DEC=8'h6C, K_COMP=8'h6D,
        K_ADD=8'h6E, K_SUB=8'h6F, K_AND=8'h70, K_OR=8'h71, K_COMPARE=8'h72,
        K_CALLI=8'h93, K_LOADI=8'h94;

    logic [7:0] codes [25] = '{K_NOP, K_CLEAR, K_JUMP, K_STORE, K_ASL, K_ASR, K_LSR,
        K_MOVE, K_CALL, K_STOREI, K_LOAD, K_INC, K_DEC, K_COMP, K_ADD, K_SUB, K_AND,
        K_OR, K_COMPARE, K_CALLI, K_LOADI, 8'h01, 8'h28, 8'h48, 8'hFF};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s step=%b op=%h dst=%0d actual=%0h expected=%0h",
                     tag, stage_strb, ir_opcode, ir_dst, act, exp);
        end
    endtask

    task automatic check_step(input int s, input logic [7:0] op, input int d);
        bit f1 = (s == 0), f2 = (s == 1), e1 = (s == 3), e2 = (s == 4);
        bit e3 = (s == 5), e4 = (s == 6);
        bit wr, pc, al, mk, md, legal;
        int x_mar, x_mdr, x_reg, x_shf, x_alu, x_cin, x_bus;
        legal = 0;
        for (int i = 0; i < 21; i++) if (codes[i] == op) legal = 1;
        x_mar = f1 | e1 | e2;
        x_mdr = f2 | (e2 & (op == K_LOAD)) | (e3 & (op == K_LOADI));
        wr = e4 | (e3 & (op inside {K_LOAD, K_ADD, K_INC, K_DEC, K_COMP}))
                | (e2 & (op inside {K_ASL, K_MOVE, K_CALL, K_CALLI}))
                | (e1 & (op == K_CLEAR));
        x_reg = wr ? (1 << d) : 0;
        x_shf = 0;
        if (op == K_ASR) x_shf = 2;
        if (op == K_ASL) x_shf = 1;
        if (op == K_LSR) x_shf = 3;
        x_cin = e3 & (op == K_INC);
        x_alu = 0;
        if (e2 && (op == K_COMP || op == K_DEC)) x_alu = 7;
        if (e3) begin
            if (op inside {K_COMP, K_AND}) x_alu += 4;
            if (op inside {K_SUB, K_COMPARE, K_DEC, K_INC, K_ADD, K_AND}) x_alu += 2;
            if (op inside {K_DEC, K_INC, K_ADD, K_OR}) x_alu += 1;
        end
        pc = e2 & (op inside {K_CALL, K_CALLI});
        al = (e1 & (op == K_CLEAR)) | ((e2 | e3) & (op inside {K_INC, K_DEC, K_COMP}));
        mk = (e1 & (op inside {K_LOAD, K_JUMP, K_STORE})) | (e3 & (op == K_CALL));
        md = (e3 & (op == K_LOAD)) | e4;
        x_bus = pc ? 2 : al ? 1 : mk ? 4 : md ? 5 : 0;

        chk("R2 ld_mar", int'(ld_mar), x_mar);
        chk("R3 ld_mdr", int'(ld_mdr), x_mdr);
        chk("R4 ld_reg", int'(ld_reg), x_reg);
        chk("R5 shf_fn", int'(shf_fn), x_shf);
        chk("R6 alu_cin", int'(alu_cin), x_cin);
        chk("R7 alu_fn", int'(alu_fn), x_alu);
        chk("R8 bus_sel", int'(bus_sel), x_bus);
        if (!legal) chk("R1 unassigned", int'({shf_fn, alu_fn, alu_cin}), 0);
        if (op == K_CALL && (e1 | e2 | e3)) chk("R9 call mdr", int'(ld_mdr), 0);
        if (s == 7) chk("R10 idle", int'({ld_mar, ld_mdr, ld_reg, alu_fn, alu_cin, bus_sel}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: no strobe, NOP
        chk("R10 reset", int'({ld_mar, ld_mdr, ld_reg, shf_fn, alu_fn, alu_cin, bus_sel}), 0);
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 25; k++) begin
                @(posedge clk);
                #1;
                stage_strb = (s < 7) ? 7'(1 << s) : 7'd0;
                ir_opcode  = codes[k];
                ir_dst     = 3'((s + k) % 8);
                @(negedge clk);
                check_step(s, codes[k], (s + k) % 8);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule